// File: doc/BRIEF.md
# Radio Data Block Synchronization Guard

This block decides whether a receiver of a radio data stream is locked to the 26-bit block structure of that stream. Offset detection and error correction sit upstream. Each received block arrives as a one-cycle strobe, together with a 3-bit offset code and an uncorrectable-error flag. The guard acquires lock under one of two selectable rules. It keeps lock with a flywheel that expects the next offset in the cycle on every block. It drops lock after a programmable run of bad blocks.

Two request lines force the block out of lock and keep it out. One comes from a control register and one from a pin; the two are ORed. While either is high, capture is held off. Acquisition starts again from nothing once both are low.

The block has two sync outputs. `sync_o` gives the live lock state. `blk_syc_o` is valid with `blk_vld_o` and reports the lock state at the moment each block arrived.

States:
- HOLD: a sync reset is active.
- HUNT: no reference block is held.
- ARMED: one reference block is held and the next offset is expected.
- LOCKED: synchronized.

Transitions:
- any state to HOLD when a sync reset is seen.
- HOLD to HUNT on the first cycle with the sync reset released.
- HUNT to ARMED on a valid block.
- ARMED to LOCKED on an in-order block.
- ARMED to ARMED on a tolerated miss, or on a restart from a valid out-of-order block.
- ARMED to HUNT on an invalid block when no miss is left.
- LOCKED to HUNT when the loss count is reached.

Top module: `rsync_guard`

## Requirements
- R1: Offset codes are 000 A, 001 B, 010 C, 011 C', 100 D and 101 E. Codes 110 and 111 are never valid. E is valid only when `cfg_e_ok_i`=1, and a valid E counts as in order at any position. The expected cycle is A, B, C or C', D, then back to A. A block whose valid code is E and that starts a reference makes A the next expected offset.
- R2: `sync_o` and the internal state change only on a cycle with a block strobe or an active sync reset.
- R3: With `cfg_acq_consec_i`=1, lock is reached on a block that is in order after the reference block. A valid block that is out of order becomes the new reference. An invalid block returns to HUNT. A single block never gives lock.
- R4: With `cfg_acq_consec_i`=0, lock is reached when 2 of 3 blocks are in order. The reference counts as one. After the reference, one out-of-order block is tolerated, and the block after it must match the offset two steps past the reference.
- R5: `cfg_loss_sel_i` values 0 to 7 select a loss count of 3, 4, 5, 6, 8, 10, 12 or 16. `sync_o` falls one cycle after the strobe of the N-th consecutive qualifying block while locked, and not earlier.
- R6: With `cfg_loss_on_err_i`=0, a block qualifies when it is not in order. With `cfg_loss_on_err_i`=1, a block qualifies when its uncorrectable flag is set, and order does not matter. Any block that does not qualify clears the run.
- R7: A sync reset comes from `sync_rst_reg_i` OR `sync_rst_pin_i`. `sync_o` is 0 from the cycle after the reset is seen, and strobes are ignored while it is active. After release, a full acquisition is needed. The first block that counts is one strobed at least one cycle after the release cycle.
- R8: One cycle after every strobe, `blk_vld_o` pulses for one cycle. In that cycle `blk_syc_o` equals the value `sync_o` had in the strobe cycle.
- R9: After `rst_n` goes low, `sync_o`=0 and `blk_vld_o`=0, and the block is in HUNT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| blk_stb_i | input | 1 | one-cycle strobe per received block |
| blk_ofs_i | input | 3 | detected offset code |
| blk_uncorr_i | input | 1 | block could not be corrected |
| cfg_loss_sel_i | input | 3 | loss count selector |
| cfg_loss_on_err_i | input | 1 | 1: count uncorrectable blocks, 0: count out-of-order blocks |
| cfg_acq_consec_i | input | 1 | 1: two consecutive blocks, 0: two of three |
| cfg_e_ok_i | input | 1 | accept offset E |
| sync_rst_reg_i | input | 1 | sync reset from register |
| sync_rst_pin_i | input | 1 | sync reset from pin |
| sync_o | output | 1 | live lock state |
| blk_vld_o | output | 1 | per-block flag valid |
| blk_syc_o | output | 1 | lock state at block arrival |

## Verification
A block strobe and a sync reset can fall in the same cycle. The bench provokes this by raising the pin reset in the very cycle of an in-order strobe while locked. It judges that the reset wins: `sync_o` is low one cycle later, and the per-block flag still reports the lock the block arrived under. A second collision is the last qualifying block of a run and the clearing of the loss counter. Both the run lengths and the reset behaviour are compared against counts that the bench computes itself.

// File: rtl/rsync_pkg.sv
package rsync_pkg;
    typedef enum logic [1:0] {
        S_HOLD  = 2'd0,
        S_HUNT  = 2'd1,
        S_ARMED = 2'd2,
        S_LOCK  = 2'd3
    } rsync_state_t;

    localparam int OFS_W = 3;
    localparam int POS_W = 2;
    localparam int CNT_W = 5;

    function automatic logic [CNT_W-1:0] loss_limit(input logic [2:0] sel);
        logic [CNT_W-1:0] r;
        if (sel < 3'd4)       r = CNT_W'(sel) + CNT_W'(3);
        else if (sel == 3'd7) r = CNT_W'(16);
        else                  r = CNT_W'(sel) << 1;
        return r;
    endfunction
endpackage

// File: rtl/rsync_ofs_judge.sv
module rsync_ofs_judge
    import rsync_pkg::*;
(
    input  logic [OFS_W-1:0] ofs_i,
    input  logic             e_ok_i,
    input  logic [POS_W-1:0] exp_i,
    output logic             valid_o,
    output logic [POS_W-1:0] pos_o,
    output logic             in_order_o
);
    logic is_e;

    always_comb begin
        is_e    = (ofs_i == 3'b101);
        valid_o = (ofs_i <= 3'b100) || (is_e && e_ok_i);
        unique case (ofs_i)
            3'b000:  pos_o = 2'd0;
            3'b001:  pos_o = 2'd1;
            3'b010,
            3'b011:  pos_o = 2'd2;
            default: pos_o = 2'd3;
        endcase
        in_order_o = valid_o && (is_e || (pos_o == exp_i));
    end

    always_comb begin
        assert_invalid_codes_R1: assert (!(ofs_i[2:1] == 2'b11 && valid_o));
    end
endmodule

// File: rtl/rsync_loss_ctr.sv
module rsync_loss_ctr
    import rsync_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       locked_i,
    input  logic       step_i,
    input  logic       qual_i,
    input  logic [2:0] sel_i,
    output logic       lost_o
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;

    always_comb begin
        lim    = loss_limit(sel_i);
        lost_o = step_i && qual_i && ((cnt + CNT_W'(1)) == lim);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cnt <= '0;
        else if (!locked_i)          cnt <= '0;
        else if (step_i)             cnt <= (qual_i && !lost_o) ? cnt + CNT_W'(1) : '0;
    end

    assert_cnt_below_max_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CNT_W'(16));
    assert_clear_on_good_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_i && step_i && !qual_i) |=> (cnt == '0));
endmodule

// File: rtl/rsync_acq_fsm.sv
module rsync_acq_fsm
    import rsync_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb_i,
    input  logic             rst_any_i,
    input  logic             valid_i,
    input  logic [POS_W-1:0] pos_i,
    input  logic             in_order_i,
    input  logic             consec_i,
    input  logic             lost_i,
    output rsync_state_t     state_o,
    output logic [POS_W-1:0] exp_o
);
    rsync_state_t     nxt;
    logic [POS_W-1:0] exp_n;
    logic             miss, miss_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_o <= S_HUNT;
            exp_o   <= '0;
            miss    <= 1'b0;
        end else begin
            state_o <= nxt;
            exp_o   <= exp_n;
            miss    <= miss_n;
        end
    end

    always_comb begin
        nxt    = state_o;
        exp_n  = exp_o;
        miss_n = miss;
        if (rst_any_i) begin
            nxt    = S_HOLD;
            miss_n = 1'b0;
        end else begin
            unique case (state_o)
                S_HOLD: nxt = S_HUNT;
                S_HUNT: if (stb_i && valid_i) begin
                    nxt    = S_ARMED;
                    exp_n  = pos_i + POS_W'(1);
                    miss_n = 1'b0;
                end
                S_ARMED: if (stb_i) begin
                    if (in_order_i) begin
                        nxt   = S_LOCK;
                        exp_n = exp_o + POS_W'(1);
                    end else if (!consec_i && !miss) begin
                        miss_n = 1'b1;
                        exp_n  = exp_o + POS_W'(1);
                    end else if (valid_i) begin
                        exp_n  = pos_i + POS_W'(1);
                        miss_n = 1'b0;
                    end else begin
                        nxt = S_HUNT;
                    end
                end
                S_LOCK: if (stb_i) begin
                    exp_n = exp_o + POS_W'(1);
                    if (lost_i) nxt = S_HUNT;
                end
            endcase
        end
    end

    assert_reset_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_any_i |=> (state_o == S_HOLD));
    assert_lock_needs_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_o == S_LOCK) |-> $past(stb_i && in_order_i && !rst_any_i));
    assert_no_single_block_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == S_HUNT && stb_i) |=> (state_o != S_LOCK));
endmodule

// File: rtl/rsync_guard.sv
module rsync_guard
    import rsync_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       blk_stb_i,
    input  logic [2:0] blk_ofs_i,
    input  logic       blk_uncorr_i,
    input  logic [2:0] cfg_loss_sel_i,
    input  logic       cfg_loss_on_err_i,
    input  logic       cfg_acq_consec_i,
    input  logic       cfg_e_ok_i,
    input  logic       sync_rst_reg_i,
    input  logic       sync_rst_pin_i,
    output logic       sync_o,
    output logic       blk_vld_o,
    output logic       blk_syc_o
);
    rsync_state_t     state;
    logic [POS_W-1:0] exp_pos, pos;
    logic             valid, in_order, lost, rst_any, locked, step, qual;

    always_comb begin
        rst_any = sync_rst_reg_i | sync_rst_pin_i;
        locked  = (state == S_LOCK);
        step    = blk_stb_i && locked && !rst_any;
        qual    = cfg_loss_on_err_i ? blk_uncorr_i : !in_order;
        sync_o  = locked;
    end

    rsync_ofs_judge u_judge (
        .ofs_i(blk_ofs_i), .e_ok_i(cfg_e_ok_i), .exp_i(exp_pos),
        .valid_o(valid), .pos_o(pos), .in_order_o(in_order)
    );

    rsync_loss_ctr u_loss (
        .clk(clk), .rst_n(rst_n), .locked_i(locked), .step_i(step),
        .qual_i(qual), .sel_i(cfg_loss_sel_i), .lost_o(lost)
    );

    rsync_acq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .stb_i(blk_stb_i), .rst_any_i(rst_any),
        .valid_i(valid), .pos_i(pos), .in_order_i(in_order),
        .consec_i(cfg_acq_consec_i), .lost_i(lost),
        .state_o(state), .exp_o(exp_pos)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blk_vld_o <= 1'b0;
            blk_syc_o <= 1'b0;
        end else begin
            blk_vld_o <= blk_stb_i;
            if (blk_stb_i) blk_syc_o <= locked;
        end
    end

    assert_syc_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        blk_stb_i |=> (blk_vld_o && blk_syc_o == $past(sync_o)));
    assert_fall_has_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync_o) |-> $past(blk_stb_i || rst_any));
endmodule

// File: tb/rsync_guard_bench.sv
module rsync_guard_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stb = 1'b0;
    logic [2:0] ofs = 3'd0;
    logic       unc = 1'b0;
    logic [2:0] lsel = 3'd2;
    logic       lerr = 1'b0, consec = 1'b0, eok = 1'b0, sreg = 1'b0, spin = 1'b0;
    logic       sync, vld, syc;
    int         errors = 0, checks = 0;
    int         bpos = 0;

    always #4 clk = ~clk;

    rsync_guard u_rsync_guard (
        .clk(clk), .rst_n(rst_n), .blk_stb_i(stb), .blk_ofs_i(ofs), .blk_uncorr_i(unc),
        .cfg_loss_sel_i(lsel), .cfg_loss_on_err_i(lerr), .cfg_acq_consec_i(consec),
        .cfg_e_ok_i(eok), .sync_rst_reg_i(sreg), .sync_rst_pin_i(spin),
        .sync_o(sync), .blk_vld_o(vld), .blk_syc_o(syc)
    );

    task automatic chk(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int f_pos(input int c);
        return (c <= 1) ? c : (c <= 3) ? 2 : 3;
    endfunction
    function automatic bit f_valid(input int c, input bit rm);
        return (c <= 4) || (c == 5 && rm);
    endfunction
    function automatic bit f_inord(input int c, input int e, input bit rm);
        return f_valid(c, rm) && (c == 5 || f_pos(c) == (e % 4));
    endfunction
    function automatic int code_of(input int p);
        return (p % 4 == 3) ? 4 : (p % 4);
    endfunction
    function automatic int lim_of(input int s);
        return (s < 4) ? s + 3 : (s == 7) ? 16 : 2 * s;
    endfunction

    // one block; per-block flag checked for R8
    task automatic send(input int c, input bit e);
        bit pre;
        pre = sync;
        ofs = 3'(c); unc = e; stb = 1'b1;
        @(negedge clk);
        stb = 1'b0;
        chk("R8 vld", vld, 1);
        chk("R8 syc", syc, pre);
        @(negedge clk);
        chk("R8 vld pulse", vld, 0);
        bpos++;
    endtask

    task automatic sreset();
        sreg = 1'b1;
        @(negedge clk);
        sreg = 1'b0;
        @(negedge clk);
        @(negedge clk);
        bpos = 0;
    endtask

    task automatic lock_ab();
        consec = 1'b1;
        sreset();
        send(0, 0);
        send(1, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        chk("R9 sync", sync, 0);
        chk("R9 vld", vld, 0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R9 hunt", sync, 0);

        // R1 R3: exhaustive pairs, consecutive rule
        consec = 1'b1;
        for (int rm = 0; rm < 2; rm++)
            for (int a = 0; a < 8; a++)
                for (int b = 0; b < 8; b++) begin
                    eok = rm[0];
                    sreset();
                    send(a, 0);
                    chk("R3 single block", sync, 0);
                    send(b, 0);
                    chk("R1 R3 pair", sync,
                        int'(f_valid(a, rm[0]) && f_inord(b, f_pos(a) + 1, rm[0])));
                end

        // R4: exhaustive triples, 2 of 3 rule
        consec = 1'b0; eok = 1'b1;
        for (int a = 0; a < 8; a++)
            for (int b = 0; b < 8; b++)
                for (int c = 0; c < 8; c++) begin
                    bit e2, e3;
                    sreset();
                    send(a, 0);
                    send(b, 0);
                    e2 = f_valid(a, 1) && f_inord(b, f_pos(a) + 1, 1);
                    chk("R4 after two", sync, int'(e2));
                    send(c, 0);
                    e3 = (f_valid(a, 1) && (e2 || f_inord(c, f_pos(a) + 2, 1))) ||
                         (!f_valid(a, 1) && f_valid(b, 1) && f_inord(c, f_pos(b) + 1, 1));
                    chk("R4 after three", sync, int'(e3));
                end

        // R3 restart vs R4 window: A, D, A
        consec = 1'b1; sreset(); send(0, 0); send(4, 0); send(0, 0);
        chk("R3 restart", sync, 1);
        consec = 1'b0; sreset(); send(0, 0); send(4, 0); send(0, 0);
        chk("R4 no restart", sync, 0);

        // R5 R6: every loss count under both criteria
        for (int crit = 0; crit < 2; crit++)
            for (int s = 0; s < 8; s++) begin
                lerr = crit[0]; lsel = 3'(s);
                lock_ab();
                chk("R5 locked", sync, 1);
                for (int k = 1; k < lim_of(s); k++)
                    if (crit == 0) send(6, 0); else send(code_of(bpos), 1);
                chk("R5 before limit", sync, 1);
                if (crit == 0) send(6, 0); else send(code_of(bpos), 1);
                chk("R5 at limit", sync, 0);
            end

        // R6: the other criterion never counts
        lsel = 3'd0; lerr = 1'b1; lock_ab();
        for (int k = 0; k < 20; k++) send(6, 0);
        chk("R6 order ignored", sync, 1);
        lerr = 1'b0; lock_ab();
        for (int k = 0; k < 20; k++) send(code_of(bpos), 1);
        chk("R6 error ignored", sync, 1);
        // R6: good block clears the run (limit 3)
        lock_ab();
        send(6, 0); send(6, 0); send(code_of(bpos), 0); send(6, 0); send(6, 0);
        chk("R6 run cleared", sync, 1);
        send(6, 0);
        chk("R6 run complete", sync, 0);

        // R2: idle cycles leave lock alone
        lock_ab();
        repeat (12) @(negedge clk);
        chk("R2 idle", sync, 1);

        // R7: pin reset colliding with an in-order strobe
        spin = 1'b1;
        send(code_of(bpos), 0);
        chk("R7 reset wins", sync, 0);
        send(code_of(bpos), 0); send(code_of(bpos), 0);
        chk("R7 strobes ignored", sync, 0);
        spin = 1'b0;
        @(negedge clk);
        bpos = 0;
        send(0, 0);
        chk("R7 fresh acquisition", sync, 0);
        send(1, 0);
        chk("R7 reacquired", sync, 1);
        sreg = 1'b1;
        @(negedge clk);
        chk("R7 register reset", sync, 0);
        sreg = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule